// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block runs when the translation buffer misses. It takes the faulting virtual address and the base of the current process's region table. It then reads three levels of tables held in resident memory, one read at a time. The first read takes a segment-table pointer from the region table. The second takes a page-table pointer from that segment table. The third takes the page-table entry for the addressed page. If that entry is valid, the block makes a fourth read for the entry of the partner page, which is the other page of the even/odd pair. It then writes both frames into one paired buffer slot in a single refill pulse. If the addressed entry is invalid, the block raises a one-cycle page-fault pulse and makes no refill.

Tables live in unmapped memory, so every address the block sends out is physical. Region and segment slots that are not allocated point at shared null tables whose entries all read as invalid. A walk through them ends in a fault with no special logic. Retrying the instruction and loading the page are left to the logic around the block.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, busy, rd_req, fill_valid and fault_valid are all low.
- R2: The first read of a walk goes to miss_root + 4 × region, where the region is vaddr[31:25].
- R3: The second read goes to the 32-bit word returned by the first read, plus 4 × segment, where the segment is vaddr[24:17].
- R4: The third read goes to the 32-bit word returned by the second read, plus 4 × page, where the page is vaddr[16:12].
- R5: If the third word has bit 31 set (the valid bit), a fourth read goes to the same page-table base plus 4 × (page XOR 1).
- R6: After the fourth read, fill_valid pulses for exactly one cycle. fill_vpair is vaddr[31:13]. The even and odd frame outputs carry bits [19:0] of the entries at the even and odd page index. Their valid outputs carry bit 31 of those entries. A partner entry that is invalid still refills and does not fault.
- R7: If the third word has bit 31 clear, fault_valid pulses for one cycle with fault_vaddr equal to the missed address. There is no fourth read and no refill.
- R8: Only one read is outstanding at a time. rd_req stays high with rd_addr unchanged until the cycle in which rd_resp_valid is seen.
- R9: busy rises in the cycle after a miss is accepted and stays high through the refill or fault pulse. A miss_valid presented while busy is ignored.
- R10: A walk through a region or segment slot that points at a null table ends in a fault after exactly three reads. This includes region numbers 64 to 95.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_root | input | 32 | Physical base of the process region table |
| busy | output | 1 | Walk in progress |
| rd_req | output | 1 | Memory read request, held until response |
| rd_addr | output | 32 | Physical read address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data word |
| fill_valid | output | 1 | Refill pulse for the paired slot |
| fill_vpair | output | 19 | Virtual page-pair number |
| fill_frame_even | output | 20 | Frame of the even page |
| fill_frame_odd | output | 20 | Frame of the odd page |
| fill_valid_even | output | 1 | Valid bit of the even entry |
| fill_valid_odd | output | 1 | Valid bit of the odd entry |
| fault_valid | output | 1 | Page-fault pulse |
| fault_vaddr | output | 32 | Address that faulted |

## Verification
A corrupted walk state shows up at rd_addr within one read. The memory model recomputes each expected address from its own table contents, so a wrong index, a wrong base or a skipped level is reported on the very request that carries it. A wrong pair order or a lost valid bit shows up in the refill pulse at the end of the same walk. A stuck state shows up as a missing pulse, or as busy staying high in the cycle after the pulse.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REGION,
    ST_SEG,
    ST_PTE,
    ST_PARTNER,
    ST_REFILL,
    ST_FAULT
  } walk_state_t;
endpackage

// File: rtl/walk_index.sv
// Splits the page-number part of a virtual address into byte offsets
// for each table level (entries are 4 bytes).
module walk_index #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int PAGE_W = 5,
  parameter int SEG_W  = 8
) (
  input  logic [ADDR_W-1:OFF_W] vpn,
  output logic [ADDR_W-1:0]     region_off,
  output logic [ADDR_W-1:0]     seg_off,
  output logic [ADDR_W-1:0]     page_off,
  output logic [ADDR_W-1:0]     partner_off
);
  localparam int PAGE_LO = OFF_W;
  localparam int SEG_LO  = OFF_W + PAGE_W;
  localparam int REG_LO  = SEG_LO + SEG_W;
  localparam int REG_W   = ADDR_W - REG_LO;

  logic [REG_W-1:0]  region_idx;
  logic [SEG_W-1:0]  seg_idx;
  logic [PAGE_W-1:0] page_idx;

  always_comb begin
    region_idx  = vpn[ADDR_W-1:REG_LO];
    seg_idx     = vpn[REG_LO-1:SEG_LO];
    page_idx    = vpn[SEG_LO-1:PAGE_LO];
    region_off  = ADDR_W'({region_idx, 2'b00});
    seg_off     = ADDR_W'({seg_idx, 2'b00});
    page_off    = ADDR_W'({page_idx, 2'b00});
    partner_off = ADDR_W'({page_idx ^ PAGE_W'(1), 2'b00});
  end
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import walk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 20,
  parameter int VALID_BIT = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  input  logic [ADDR_W-1:0]     miss_vaddr,
  input  logic [ADDR_W-1:0]     miss_root,
  output logic [ADDR_W-1:0]     idx_va,
  input  logic [ADDR_W-1:0]     region_off,
  input  logic [ADDR_W-1:0]     seg_off,
  input  logic [ADDR_W-1:0]     page_off,
  input  logic [ADDR_W-1:0]     partner_off,
  output logic                  busy,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_resp_valid,
  input  logic [ADDR_W-1:0]     rd_resp_data,
  output logic                  fill_valid,
  output logic [ADDR_W-OFF_W-2:0] fill_vpair,
  output logic [FRAME_W-1:0]    fill_frame_even,
  output logic [FRAME_W-1:0]    fill_frame_odd,
  output logic                  fill_valid_even,
  output logic                  fill_valid_odd,
  output logic                  fault_valid,
  output logic [ADDR_W-1:0]     fault_vaddr
);
  walk_state_t         state;
  logic [ADDR_W-1:0]   va_q;
  logic [ADDR_W-1:0]   pt_base_q;
  logic [FRAME_W-1:0]  main_frame_q;
  logic                main_v_q;
  logic                page_odd;

  // Index logic sees the incoming address while idle, the latched one after.
  assign idx_va   = (state == ST_IDLE) ? miss_vaddr : va_q;
  assign page_odd = va_q[OFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      va_q            <= '0;
      pt_base_q       <= '0;
      main_frame_q    <= '0;
      main_v_q        <= 1'b0;
      rd_req          <= 1'b0;
      rd_addr         <= '0;
      fill_valid      <= 1'b0;
      fill_frame_even <= '0;
      fill_frame_odd  <= '0;
      fill_valid_even <= 1'b0;
      fill_valid_odd  <= 1'b0;
      fault_valid     <= 1'b0;
    end else begin
      fill_valid  <= 1'b0;
      fault_valid <= 1'b0;
      case (state)
        ST_IDLE: if (miss_valid) begin
          va_q    <= miss_vaddr;
          rd_addr <= miss_root + region_off;
          rd_req  <= 1'b1;
          state   <= ST_REGION;
        end
        ST_REGION: if (rd_resp_valid) begin
          rd_addr <= rd_resp_data + seg_off;
          state   <= ST_SEG;
        end
        ST_SEG: if (rd_resp_valid) begin
          pt_base_q <= rd_resp_data;
          rd_addr   <= rd_resp_data + page_off;
          state     <= ST_PTE;
        end
        ST_PTE: if (rd_resp_valid) begin
          main_frame_q <= rd_resp_data[FRAME_W-1:0];
          main_v_q     <= rd_resp_data[VALID_BIT];
          if (rd_resp_data[VALID_BIT]) begin
            rd_addr <= pt_base_q + partner_off;
            state   <= ST_PARTNER;
          end else begin
            rd_req      <= 1'b0;
            fault_valid <= 1'b1;
            state       <= ST_FAULT;
          end
        end
        ST_PARTNER: if (rd_resp_valid) begin
          rd_req     <= 1'b0;
          fill_valid <= 1'b1;
          if (page_odd) begin
            fill_frame_even <= rd_resp_data[FRAME_W-1:0];
            fill_valid_even <= rd_resp_data[VALID_BIT];
            fill_frame_odd  <= main_frame_q;
            fill_valid_odd  <= main_v_q;
          end else begin
            fill_frame_even <= main_frame_q;
            fill_valid_even <= main_v_q;
            fill_frame_odd  <= rd_resp_data[FRAME_W-1:0];
            fill_valid_odd  <= rd_resp_data[VALID_BIT];
          end
          state <= ST_REFILL;
        end
        ST_REFILL: state <= ST_IDLE;
        ST_FAULT:  state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state != ST_IDLE);
  assign fill_vpair  = va_q[ADDR_W-1:OFF_W+1];
  assign fault_vaddr = va_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_req && !fill_valid && !fault_valid));
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_resp_valid) |=> (rd_req && $stable(rd_addr)));
  assert_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && miss_valid) |=> (busy && rd_req));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (!fill_valid && !busy));
  assert_no_dual_R7: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!fill_valid && !rd_req));
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 12,
  parameter int PAGE_W    = 5,
  parameter int SEG_W     = 8,
  parameter int FRAME_W   = 20,
  parameter int VALID_BIT = 31,
  localparam int VPAIR_W  = ADDR_W - OFF_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               miss_valid,
  input  logic [ADDR_W-1:0]  miss_vaddr,
  input  logic [ADDR_W-1:0]  miss_root,
  output logic               busy,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_resp_valid,
  input  logic [ADDR_W-1:0]  rd_resp_data,
  output logic               fill_valid,
  output logic [VPAIR_W-1:0] fill_vpair,
  output logic [FRAME_W-1:0] fill_frame_even,
  output logic [FRAME_W-1:0] fill_frame_odd,
  output logic               fill_valid_even,
  output logic               fill_valid_odd,
  output logic               fault_valid,
  output logic [ADDR_W-1:0]  fault_vaddr
);
  logic [ADDR_W-1:0] idx_va, region_off, seg_off, page_off, partner_off;

  walk_index #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .SEG_W(SEG_W)) index_i (
    .vpn(idx_va[ADDR_W-1:OFF_W]), .region_off(region_off), .seg_off(seg_off),
    .page_off(page_off), .partner_off(partner_off)
  );

  walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .VALID_BIT(VALID_BIT)) fsm_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_root(miss_root), .idx_va(idx_va), .region_off(region_off),
    .seg_off(seg_off), .page_off(page_off), .partner_off(partner_off),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .fill_valid(fill_valid), .fill_vpair(fill_vpair),
    .fill_frame_even(fill_frame_even), .fill_frame_odd(fill_frame_odd),
    .fill_valid_even(fill_valid_even), .fill_valid_odd(fill_valid_odd),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr)
  );
endmodule

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic rst, miss_valid, busy, rd_req, rd_resp_valid, fill_valid;
  logic fill_valid_even, fill_valid_odd, fault_valid;
  logic [31:0] miss_vaddr, miss_root, rd_addr, rd_resp_data, fault_vaddr;
  logic [18:0] fill_vpair;
  logic [19:0] fill_frame_even, fill_frame_odd;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .miss_root(miss_root), .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .fill_valid(fill_valid), .fill_vpair(fill_vpair),
    .fill_frame_even(fill_frame_even), .fill_frame_odd(fill_frame_odd),
    .fill_valid_even(fill_valid_even), .fill_valid_odd(fill_valid_odd),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr)
  );

  localparam logic [31:0] ROOT = 32'h3000;
  logic [31:0] mem [16384];

  int checks = 0, errors = 0, mchecks = 0, merrors = 0;
  int rd_count, delay;
  logic [31:0] cur_va;
  logic [31:0] walk_addr [4];

  // Expected address for read k, from the bench's own tables (R2..R5).
  function automatic logic [31:0] exp_addr(int k);
    case (k)
      0: return ROOT + {23'd0, cur_va[31:25], 2'b00};
      1: return mem[walk_addr[0][15:2]] + {22'd0, cur_va[24:17], 2'b00};
      2: return mem[walk_addr[1][15:2]] + {25'd0, cur_va[16:12], 2'b00};
      default: return mem[walk_addr[1][15:2]] + {25'd0, cur_va[16:13], ~cur_va[12], 2'b00};
    endcase
  endfunction

  // Memory model with per-walk latency; verifies every request address.
  logic pending; int cnt; logic [31:0] lat_addr;
  always @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0; rd_resp_valid <= 1'b0; rd_resp_data <= '0; cnt <= 0;
    end else begin
      rd_resp_valid <= 1'b0;
      if (rd_req && !pending && !rd_resp_valid) begin
        mchecks++;
        if (rd_count > 3 || rd_addr !== exp_addr(rd_count)) begin
          merrors++;
          $display("FAIL R2/R3/R4/R5 read %0d addr act=%h exp=%h", rd_count, rd_addr,
                   (rd_count > 3) ? 32'hx : exp_addr(rd_count));
        end
        if (rd_count < 4) walk_addr[rd_count] = rd_addr;
        rd_count++;
        pending <= 1'b1; cnt <= delay; lat_addr <= rd_addr;
      end else if (pending) begin
        if (rd_addr !== lat_addr || !rd_req) begin
          merrors++;
          $display("FAIL R8 request changed act=%h exp=%h", rd_addr, lat_addr);
        end
        if (cnt == 0) begin
          pending <= 1'b0; rd_resp_valid <= 1'b1; rd_resp_data <= mem[lat_addr[15:2]];
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // {vaddr, fault, even frame, odd frame, even valid, odd valid}
  localparam logic [74:0] VEC [8] = '{
    {7'd3,   8'd5,   5'd4,  12'h123, 1'b0, 20'h0A004, 20'h0A005, 1'b1, 1'b1},
    {7'd3,   8'd5,   5'd31, 12'hFFF, 1'b0, 20'h0A01E, 20'h0A01F, 1'b1, 1'b1},
    {7'd3,   8'd200, 5'd6,  12'h000, 1'b0, 20'h0B006, 20'h00777, 1'b1, 1'b0},
    {7'd3,   8'd200, 5'd7,  12'h010, 1'b1, 20'h0,     20'h0,     1'b0, 1'b0},
    {7'd3,   8'd200, 5'd9,  12'h020, 1'b1, 20'h0,     20'h0,     1'b0, 1'b0},
    {7'd70,  8'd5,   5'd4,  12'h444, 1'b1, 20'h0,     20'h0,     1'b0, 1'b0},
    {7'd100, 8'd0,   5'd0,  12'h001, 1'b0, 20'h0C000, 20'h0C001, 1'b1, 1'b1},
    {7'd3,   8'd6,   5'd2,  12'h0AB, 1'b1, 20'h0,     20'h0,     1'b0, 1'b0}
  };

  task automatic run_walk(input logic [74:0] v, input int dly, input bit poke);
    logic [31:0] va;
    bit done = 0;
    va = v[74:43];
    cur_va = va; rd_count = 0; delay = dly;
    @(negedge clk);
    miss_valid = 1'b1; miss_vaddr = va;
    @(negedge clk);
    miss_valid = 1'b0; miss_vaddr = 32'hDEAD_BEEF;
    chk(busy === 1'b1 && rd_req === 1'b1, "R9 busy after accept", {62'd0, busy, rd_req}, 64'd3);
    for (int t = 0; t < 100 && !done; t++) begin
      if (fill_valid || fault_valid) done = 1;
      else begin
        if (poke && t == 2) begin miss_valid = 1'b1; miss_vaddr = 32'h0000_5000; end
        else miss_valid = 1'b0;
        @(negedge clk);
      end
    end
    miss_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy during pulse", {63'd0, busy}, 64'd1);
    if (v[42]) begin
      chk(fault_valid === 1'b1 && fill_valid === 1'b0, "R7 fault pulse",
          {62'd0, fault_valid, fill_valid}, 64'd2);
      chk(fault_vaddr === va, "R7 fault address", {32'd0, fault_vaddr}, {32'd0, va});
      chk(rd_count == 3, "R7/R10 three reads", rd_count, 3);
    end else begin
      chk(fill_valid === 1'b1 && fault_valid === 1'b0, "R6 refill pulse",
          {62'd0, fill_valid, fault_valid}, 64'd2);
      chk(fill_vpair === va[31:13], "R6 pair number", {45'd0, fill_vpair}, {45'd0, va[31:13]});
      chk({fill_frame_even, fill_frame_odd, fill_valid_even, fill_valid_odd} === v[41:0],
          "R6 frames", {22'd0, fill_frame_even, fill_frame_odd, fill_valid_even, fill_valid_odd},
          {22'd0, v[41:0]});
      chk(rd_count == 4, "R5 four reads", rd_count, 4);
    end
    @(negedge clk);
    chk(busy === 1'b0 && fill_valid === 1'b0 && fault_valid === 1'b0, "R6/R9 return to idle",
        {61'd0, busy, fill_valid, fault_valid}, 64'd0);
    @(negedge clk);
    chk(busy === 1'b0 && rd_req === 1'b0, "R9 ignored miss started nothing",
        {62'd0, busy, rd_req}, 64'd0);
  endtask

  bit finished = 0;
  initial begin
    for (int i = 0; i < 100000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16384; i++) mem[i] = 32'h0;
    for (int i = 0; i < 128; i++) mem[(ROOT >> 2) + i] = 32'h0400;   // null segment table
    mem[(ROOT >> 2) + 3]   = 32'h1000;
    mem[(ROOT >> 2) + 100] = 32'h1400;
    for (int i = 0; i < 256; i++) begin
      mem[(32'h0400 >> 2) + i] = 32'h0800;                            // null page table
      mem[(32'h1000 >> 2) + i] = 32'h0800;
      mem[(32'h1400 >> 2) + i] = 32'h0800;
    end
    mem[(32'h1000 >> 2) + 5]   = 32'h2000;
    mem[(32'h1000 >> 2) + 200] = 32'h2100;
    mem[(32'h1400 >> 2) + 0]   = 32'h2200;
    for (int i = 0; i < 32; i++) begin
      mem[(32'h2000 >> 2) + i] = 32'h8000_0000 | (32'h0A000 + i);
      mem[(32'h2200 >> 2) + i] = 32'h8000_0000 | (32'h0C000 + i);
    end
    mem[(32'h2100 >> 2) + 6] = 32'h8000_B006;
    mem[(32'h2100 >> 2) + 7] = 32'h0000_0777;
    mem[(32'h2100 >> 2) + 8] = 32'h8000_B008;
    mem[(32'h2100 >> 2) + 9] = 32'h0000_0009;

    rst = 1'b1; miss_valid = 1'b0; miss_vaddr = '0; miss_root = ROOT;
    rd_count = 0; delay = 0; cur_va = '0;
    repeat (3) @(negedge clk);
    chk(busy === 0 && rd_req === 0 && fill_valid === 0 && fault_valid === 0, "R1 reset state",
        {60'd0, busy, rd_req, fill_valid, fault_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 0 && rd_req === 0, "R1 idle after reset", {62'd0, busy, rd_req}, 64'd0);

    for (int i = 0; i < 8; i++) run_walk(VEC[i], i % 3, 1'b0);

    // Directed: miss presented mid-walk is ignored (R9), long stall (R8).
    run_walk(VEC[1], 5, 1'b1);
    // Directed: reserved region through null tables faults (R10).
    run_walk({7'd95, 8'd255, 5'd31, 12'h0, 1'b1, 42'd0}, 0, 1'b0);
    run_walk({7'd64, 8'd0, 5'd0, 12'h0, 1'b1, 42'd0}, 1, 1'b0);

    // Reset mid-walk returns to idle (R1).
    cur_va = VEC[0][74:43]; rd_count = 0; delay = 4;
    @(negedge clk); miss_valid = 1'b1; miss_vaddr = VEC[0][74:43];
    @(negedge clk); miss_valid = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(busy === 0 && rd_req === 0, "R1 reset aborts walk", {62'd0, busy, rd_req}, 64'd0);
    repeat (8) @(negedge clk);
    run_walk(VEC[6], 2, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors + merrors, checks + mchecks);
    $finish;
  end
endmodule